// File: doc/BRIEF.md
# Serial Gain Word Load Interface

This block is the digital control front end of a programmable-gain line driver. A host writes an 8-bit gain code over three wires: a serial data line, a serial clock and an active-low load gate. All three pins, plus an active-low power-down pin, are brought into the system clock domain through two-flop synchronizers. Their edges are detected there, so no logic is clocked from a pin. The received bits pass through a two-stage shift register. A rising serial clock captures the data bit into a holding stage. A falling serial clock pushes that bit into the word, most significant bit first.

While the gate is low, the word may be shifted and the applied gain is held. When the gate rises, the word is copied into the output latch in one step, and shifting stops until the gate falls again. The latch drives the raw gain code and an attenuation figure in quarter-dB units. Each code step is 0.75 dB, so the figure is three times the code, clamped at 214 (53.5 dB). Each load raises a one-cycle strobe. A flag reports whether exactly eight serial bits arrived since the gate last fell. The power-down pin selects between the forward amplifier path and the reverse path.

Top module: `gain_serial_ctrl`

## Requirements
- R1: After reset, the gain code and the attenuation read 0, the forward path flag is 0, the reverse path flag is 1, and the update strobe and the eight-bit flag are 0.
- R2: A word is shifted in most significant bit first. A gate rise that follows eight complete serial clock pulses applies exactly those eight bits as the gain code.
- R3: The data bit is captured on the rising serial clock edge, so a data change between the rising and the falling edge has no effect. The word advances only on the falling edge, so a final rising edge with no falling edge before the gate rises leaves that bit out of the word.
- R4: While the gate is low, the gain code output holds its previous value, whatever serial traffic occurs.
- R5: While the gate is high, serial clock edges neither shift the word nor count as bits.
- R6: The attenuation output equals the gain code times 3 (quarter-dB units) for codes 0 to 71.
- R7: For codes 72 to 255, the attenuation output saturates at 214.
- R8: With the power-down pin high, the forward flag is 1 and the reverse flag is 0. With the pin low, the forward flag is 0 and the reverse flag is 1. Each flag follows the pin within 5 system clock cycles.
- R9: The update strobe is high for exactly one system cycle for each gate rise, and never otherwise.
- R10: The eight-bit flag is loaded at each gate rise. It is 1 only if exactly eight falling serial clock edges occurred while the gate was low; 7 or 9 give 0. With nine bits, the last eight received form the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin |
| ser_dat_i | input | 1 | Serial data pin |
| load_gate_i | input | 1 | Load gate: low allows shifting, rising edge applies the word |
| pwr_on_i | input | 1 | Power-down pin, active low |
| gain_code_o | output | 8 | Applied gain code |
| atten_qdb_o | output | 8 | Attenuation in quarter-dB units, clamped at 214 |
| fwd_en_o | output | 1 | Forward amplifier path enabled |
| rev_en_o | output | 1 | Reverse amplifier path enabled |
| update_o | output | 1 | One-cycle strobe on each latch load |
| eight_bits_o | output | 1 | Exactly eight bits arrived before the last gate rise |

## Verification
A wrong holding-stage or word state shows only at the next gate rise. It appears as a gain code with a shifted, missing or stale bit, six system cycles after the gate pin rises. A corrupted bit counter appears at the same moment, on the eight-bit flag. A wrong path register shows on the forward and reverse flags within five cycles of a power-pin change. A stuck or repeated commit shows as a mismatch between the number of strobe cycles and the number of gate rises.

// File: rtl/gain_ctrl_pkg.sv
package gain_ctrl_pkg;
    localparam int unsigned WORD_W        = 8;
    localparam int unsigned CNT_W         = $clog2(WORD_W) + 2;
    localparam int unsigned QDB_PER_LSB   = 3;
    localparam int unsigned ATTEN_MAX_QDB = 214;
    localparam int unsigned PROD_W        = WORD_W + 2;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              hold_bit;
        logic [CNT_W-1:0]  nbits;
        logic              sck_prev;
    } shreg_t;

    typedef struct packed {
        logic [WORD_W-1:0] gain;
        logic [WORD_W-1:0] atten;
        logic              gate_prev;
        logic              update;
        logic              eight_ok;
        logic              fwd;
        logic              rev;
    } latch_t;
endpackage

// File: rtl/gain_sync2.sv
module gain_sync2 #(
    parameter int unsigned       W       = 4,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] safe_q, safe_d;

    always_comb begin
        meta_d = async_i;
        safe_d = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            safe_q <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            safe_q <= safe_d;
        end
    end

    assign sync_o = safe_q;
endmodule

// File: rtl/gain_shift_reg.sv
module gain_shift_reg
    import gain_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s_i,
    input  logic              sdi_s_i,
    input  logic              gate_s_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  nbits_o
);
    shreg_t st_d, st_q;
    logic   sck_rise, sck_fall;

    always_comb begin
        sck_rise = sck_s_i & ~st_q.sck_prev;
        sck_fall = ~sck_s_i & st_q.sck_prev;
        st_d          = st_q;
        st_d.sck_prev = sck_s_i;
        if (gate_s_i) begin
            st_d.nbits = '0;
        end else begin
            if (sck_rise) st_d.hold_bit = sdi_s_i;
            if (sck_fall) begin
                st_d.word = {st_q.word[WORD_W-2:0], st_q.hold_bit};
                if (st_q.nbits != {CNT_W{1'b1}}) st_d.nbits = st_q.nbits + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign nbits_o = st_q.nbits;

    // R5
    frozen_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_s_i |=> $stable(st_q.word));
endmodule

// File: rtl/gain_latch_map.sv
module gain_latch_map
    import gain_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_s_i,
    input  logic              pwr_s_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [CNT_W-1:0]  nbits_i,
    output logic [WORD_W-1:0] gain_o,
    output logic [WORD_W-1:0] atten_o,
    output logic              fwd_o,
    output logic              rev_o,
    output logic              update_o,
    output logic              eight_ok_o
);
    latch_t            st_d, st_q;
    logic              commit;
    logic [PROD_W-1:0] prod;

    always_comb begin
        commit = gate_s_i & ~st_q.gate_prev;
        prod   = PROD_W'(word_i) * PROD_W'(QDB_PER_LSB);
        st_d           = st_q;
        st_d.gate_prev = gate_s_i;
        st_d.update    = commit;
        st_d.fwd       = pwr_s_i;
        st_d.rev       = ~pwr_s_i;
        if (commit) begin
            st_d.gain     = word_i;
            st_d.eight_ok = (nbits_i == CNT_W'(WORD_W));
            if (prod > PROD_W'(ATTEN_MAX_QDB)) st_d.atten = WORD_W'(ATTEN_MAX_QDB);
            else                               st_d.atten = prod[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.gate_prev <= 1'b1;
            st_q.rev       <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_o     = st_q.gain;
    assign atten_o    = st_q.atten;
    assign fwd_o      = st_q.fwd;
    assign rev_o      = st_q.rev;
    assign update_o   = st_q.update;
    assign eight_ok_o = st_q.eight_ok;

    // R4
    gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.gain));
    // R9
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.update |=> !st_q.update);
    // R7
    atten_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.atten <= WORD_W'(ATTEN_MAX_QDB));
    // R8
    path_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_s_i |=> (st_q.fwd && !st_q.rev));
endmodule

// File: rtl/gain_serial_ctrl.sv
module gain_serial_ctrl
    import gain_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              load_gate_i,
    input  logic              pwr_on_i,
    output logic [WORD_W-1:0] gain_code_o,
    output logic [WORD_W-1:0] atten_qdb_o,
    output logic              fwd_en_o,
    output logic              rev_en_o,
    output logic              update_o,
    output logic              eight_bits_o
);
    logic [3:0]        pins_s;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  nbits;

    gain_sync2 #(.W(4), .RST_VAL(4'b0100)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({pwr_on_i, load_gate_i, ser_dat_i, ser_clk_i}),
        .sync_o (pins_s)
    );

    gain_shift_reg shreg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s_i (pins_s[0]),
        .sdi_s_i (pins_s[1]),
        .gate_s_i(pins_s[2]),
        .word_o  (word),
        .nbits_o (nbits)
    );

    gain_latch_map latch_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_s_i  (pins_s[2]),
        .pwr_s_i   (pins_s[3]),
        .word_i    (word),
        .nbits_i   (nbits),
        .gain_o    (gain_code_o),
        .atten_o   (atten_qdb_o),
        .fwd_o     (fwd_en_o),
        .rev_o     (rev_en_o),
        .update_o  (update_o),
        .eight_ok_o(eight_bits_o)
    );
endmodule

// File: tb/gain_serial_ctrl_tb_top.sv
module gain_serial_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, gate = 1'b1, pwr = 1'b0;
    logic [7:0] gain, atten;
    logic fwd, rev, upd, eight;
    int checks = 0, fails = 0, upd_seen = 0, commits = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gain_serial_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_dat_i(sdi),
        .load_gate_i(gate), .pwr_on_i(pwr), .gain_code_o(gain),
        .atten_qdb_o(atten), .fwd_en_o(fwd), .rev_en_o(rev),
        .update_o(upd), .eight_bits_o(eight)
    );

    always @(negedge clk) if (rst_n && upd) upd_seen++;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic open_gate();
        gate = 1'b0; wait_n(6);
    endtask

    task automatic close_gate();
        gate = 1'b1; commits++; wait_n(6);
    endtask

    task automatic send_bits(logic [15:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = v[i]; wait_n(4);
            sck = 1'b1; wait_n(4);
            sck = 1'b0; wait_n(4);
        end
    endtask

    task automatic load_word(logic [7:0] w);
        open_gate(); send_bits({8'h00, w}, 8); close_gate();
    endtask

    task automatic t_reset();
        check("R1 gain", gain, 0);
        check("R1 atten", atten, 0);
        check("R1 fwd", fwd, 0);
        check("R1 rev", rev, 1);
        check("R1 update", upd, 0);
        check("R1 eight", eight, 0);
    endtask

    task automatic t_map();
        load_word(8'hA5);
        check("R2 code A5", gain, 8'hA5);
        check("R10 eight bits", eight, 1);
        check("R7 atten 165", atten, 214);
        load_word(8'h10);
        check("R2 code 10", gain, 8'h10);
        check("R6 atten 16", atten, 48);
        load_word(8'd71);
        check("R6 atten 71", atten, 213);
        load_word(8'd72);
        check("R7 atten 72", atten, 214);
        load_word(8'hFF);
        check("R7 atten 255", atten, 214);
        load_word(8'd0);
        check("R6 atten 0", atten, 0);
    endtask

    task automatic t_hold();
        load_word(8'h48);
        open_gate();
        send_bits(16'h003C, 8);
        check("R4 hold during shift", gain, 8'h48);
        close_gate();
        check("R4 applied after gate", gain, 8'h3C);
    endtask

    task automatic t_edges();
        logic [7:0] w = 8'h96;
        open_gate();
        for (int i = 7; i >= 0; i--) begin
            sdi = w[i]; wait_n(4);
            sck = 1'b1; wait_n(3);
            sdi = ~w[i]; wait_n(1);
            sck = 1'b0; wait_n(4);
        end
        close_gate();
        check("R3 rising capture", gain, 8'h96);
        load_word(8'h00);
        open_gate();
        send_bits(16'h007F, 7);
        sdi = 1'b1; wait_n(4);
        sck = 1'b1; wait_n(4);
        close_gate();
        check("R3 no falling edge", gain, 8'h7F);
        check("R10 seven bits", eight, 0);
        sck = 1'b0; wait_n(4);
        send_bits(16'h00FF, 8);
        open_gate();
        close_gate();
        check("R5 gated clocks ignored", gain, 8'h7F);
        check("R5 gated clocks not counted", eight, 0);
    endtask

    task automatic t_nine();
        open_gate();
        send_bits(16'h01C3, 9);
        close_gate();
        check("R10 nine bits code", gain, 8'hC3);
        check("R10 nine bits flag", eight, 0);
        load_word(8'h5A);
        check("R10 eight again", eight, 1);
        check("R2 code 5A", gain, 8'h5A);
    endtask

    task automatic t_power();
        pwr = 1'b1; wait_n(5);
        check("R8 fwd on", fwd, 1);
        check("R8 rev off", rev, 0);
        pwr = 1'b0; wait_n(5);
        check("R8 fwd off", fwd, 0);
        check("R8 rev on", rev, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_map();
        t_hold();
        t_edges();
        t_nine();
        t_power();
        check("R9 strobe cycles", upd_seen, commits);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule